// File: doc/BRIEF.md
# Periodic ZQ Calibration Scheduler

This block decides when the ranks of a DDR3 channel receive impedance calibration commands, and for each rank it raises a busy flag that keeps all other commands away while the calibration runs. A short calibration (ZQCS) is due every time a programmable number of refresh-interval ticks has gone by. A long calibration (ZQCL) is due whenever an init-calibration pulse arrives. The block does not drive the DRAM itself. It raises a request per rank and waits for the channel's command arbiter to grant it.

The calibration work is organised in rounds, and a round covers every rank once. In parallel mode all ranks are requested together. In serial mode the ranks are requested one by one in ascending order, and each rank waits for the previous rank's busy window to close. Each busy window has a length set by a configuration field. The short window counts in units of 16 clock cycles and the long window in units of 32. At most one short calibration and one long calibration can be waiting at any time.

Top module: `zq_cal_sched`

## Requirements
- R1: After a synchronous reset, every bit of zqcs_req, zqcl_req and busy is low.
- R2: With cfg_periodic_en high, the tick counter advances on each refi_tick pulse. When a tick makes it reach cfg_interval (a value of 0 counts as 1), a short calibration becomes pending and the counter restarts from zero. A pending short calibration raises zqcs_req on the second clock edge after that tick.
- R3: While cfg_periodic_en is low, the tick counter is held at zero, refi_tick pulses are ignored, and no new short calibration becomes pending.
- R4: An init_cal pulse makes a long calibration pending and clears the tick counter. When the round controller is idle and both kinds are pending, the long calibration is started first.
- R5: However many times the interval expires while a short calibration is already pending, only one short calibration stays queued.
- R6: A request to a rank stays high until a gnt bit for that rank is seen with the request high, and it drops on the next edge. A gnt bit for a rank with no request has no effect.
- R7: busy for a rank rises on the edge that samples its grant. It stays high for cfg_short_len×16 cycles after a ZQCS or cfg_long_len×32 cycles after a ZQCL. A field value of zero gives one cycle.
- R8: With cfg_parallel high when a round starts, all ranks are requested on the same edge, and the round ends once all their busy windows have closed.
- R9: With cfg_parallel low when a round starts, rank 0 is requested first. Each next rank is requested on the second edge after the previous rank's busy falls. No request rises while any busy is high.
- R10: zqcs_req and zqcl_req are never high together on any rank, and a rank never shows a request and busy at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refi_tick | input | 1 | One-cycle pulse per refresh interval |
| init_cal | input | 1 | One-cycle pulse requesting a long calibration round |
| cfg_periodic_en | input | 1 | Enables periodic short calibration |
| cfg_interval | input | INTV_W | Refresh-interval ticks between short calibrations |
| cfg_short_len | input | SHORT_W | Short busy window in units of 16 cycles |
| cfg_long_len | input | LONG_W | Long busy window in units of 32 cycles |
| cfg_parallel | input | 1 | 1: all ranks per round together, 0: one rank at a time |
| gnt | input | NUM_RANKS | Per-rank grant from the command arbiter |
| zqcs_req | output | NUM_RANKS | Per-rank short calibration request |
| zqcl_req | output | NUM_RANKS | Per-rank long calibration request |
| busy | output | NUM_RANKS | Per-rank calibration window, blocks other commands |

## Verification
The bench builds the block with three ranks and an 8-bit interval field. With three ranks the serial round index has an unused code, and the serial round must stop at a last rank that is not a power-of-two boundary. The narrow interval field and intervals of 1 to 3 ticks make it possible to see many expiries within a few hundred cycles. These include back-to-back expiries during a long-granted round, zero-length window fields, and grants sent to ranks that have no request.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
  typedef enum logic {
    ZQ_SHORT = 1'b0,
    ZQ_LONG  = 1'b1
  } zq_kind_e;
endpackage

// File: rtl/zq_interval_timer.sv
module zq_interval_timer #(
  parameter int INTV_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              restart,
  input  logic [INTV_W-1:0] interval,
  output logic              expire
);
  logic [INTV_W-1:0] cnt;
  logic [INTV_W:0]   nxt;

  assign nxt    = {1'b0, cnt} + (INTV_W+1)'(1);
  // reaching the programmed count closes the interval; 0 behaves as 1
  assign expire = tick & en & ~restart & (nxt >= {1'b0, interval});

  always_ff @(posedge clk) begin
    if (rst || restart || !en) cnt <= '0;
    else if (expire)           cnt <= '0;
    else if (tick)             cnt <= nxt[INTV_W-1:0];
  end
endmodule

// File: rtl/zq_rank_timer.sv
module zq_rank_timer #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (load) begin
      busy <= 1'b1;
      left <= len;
    end else if (busy) begin
      if (left == LEN_W'(1)) busy <= 1'b0;
      else                   left <= left - LEN_W'(1);
    end
  end
endmodule

// File: rtl/zq_round_ctrl.sv
module zq_round_ctrl
  import zq_cal_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 expire,
  input  logic                 init_cal,
  input  logic                 cfg_parallel,
  input  logic [NUM_RANKS-1:0] gnt,
  input  logic [NUM_RANKS-1:0] busy,
  output zq_kind_e             kind,
  output logic [NUM_RANKS-1:0] load,
  output logic [NUM_RANKS-1:0] cs_req,
  output logic [NUM_RANKS-1:0] cl_req
);
  localparam int IDX_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RANKS - 1);

  logic                 pend_s, pend_l, active, serial_q;
  zq_kind_e             kind_q;
  logic [IDX_W-1:0]     idx;
  logic [NUM_RANKS-1:0] req_all, first_vec, next_vec;
  logic                 start, step, last_step;

  assign req_all   = cs_req | cl_req;
  assign load      = req_all & gnt;
  assign kind      = kind_q;
  assign start     = !active && (pend_s || pend_l);
  assign step      = active && (req_all == '0) && (busy == '0);
  assign last_step = step && (!serial_q || idx == LAST_IDX);
  assign first_vec = cfg_parallel ? '1 : NUM_RANKS'(1);
  assign next_vec  = NUM_RANKS'(1) << (idx + IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_s   <= 1'b0;
      pend_l   <= 1'b0;
      active   <= 1'b0;
      serial_q <= 1'b0;
      kind_q   <= ZQ_SHORT;
      idx      <= '0;
      cs_req   <= '0;
      cl_req   <= '0;
    end else begin
      pend_l <= (pend_l & ~start) | init_cal;
      pend_s <= (pend_s & ~(start & ~pend_l)) | expire;
      if (start) begin
        active   <= 1'b1;
        serial_q <= ~cfg_parallel;
        idx      <= '0;
        kind_q   <= pend_l ? ZQ_LONG : ZQ_SHORT;
        cl_req   <= pend_l ? first_vec : '0;
        cs_req   <= pend_l ? '0 : first_vec;
      end else if (step) begin
        if (last_step) begin
          active <= 1'b0;
        end else begin
          idx    <= idx + IDX_W'(1);
          cl_req <= (kind_q == ZQ_LONG) ? next_vec : '0;
          cs_req <= (kind_q == ZQ_LONG) ? '0 : next_vec;
        end
      end else begin
        cs_req <= cs_req & ~gnt;
        cl_req <= cl_req & ~gnt;
      end
    end
  end
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
  import zq_cal_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int INTV_W    = 21,
  parameter int SHORT_W   = 3,
  parameter int LONG_W    = 5,
  parameter int SHORT_SH  = 4,
  parameter int LONG_SH   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 refi_tick,
  input  logic                 init_cal,
  input  logic                 cfg_periodic_en,
  input  logic [INTV_W-1:0]    cfg_interval,
  input  logic [SHORT_W-1:0]   cfg_short_len,
  input  logic [LONG_W-1:0]    cfg_long_len,
  input  logic                 cfg_parallel,
  input  logic [NUM_RANKS-1:0] gnt,
  output logic [NUM_RANKS-1:0] zqcs_req,
  output logic [NUM_RANKS-1:0] zqcl_req,
  output logic [NUM_RANKS-1:0] busy
);
  localparam int SHORT_BITS = SHORT_W + SHORT_SH;
  localparam int LONG_BITS  = LONG_W + LONG_SH;
  localparam int LEN_W      = (SHORT_BITS > LONG_BITS) ? SHORT_BITS : LONG_BITS;

  logic                 expire;
  zq_kind_e             kind;
  logic [NUM_RANKS-1:0] load;
  logic [LEN_W-1:0]     short_len, long_len, sel_len, win_len;

  zq_interval_timer #(.INTV_W(INTV_W)) u_intv (
    .clk      (clk),
    .rst      (rst),
    .tick     (refi_tick),
    .en       (cfg_periodic_en),
    .restart  (init_cal),
    .interval (cfg_interval),
    .expire   (expire)
  );

  zq_round_ctrl #(.NUM_RANKS(NUM_RANKS)) u_round (
    .clk          (clk),
    .rst          (rst),
    .expire       (expire),
    .init_cal     (init_cal),
    .cfg_parallel (cfg_parallel),
    .gnt          (gnt),
    .busy         (busy),
    .kind         (kind),
    .load         (load),
    .cs_req       (zqcs_req),
    .cl_req       (zqcl_req)
  );

  always_comb begin
    short_len = LEN_W'(cfg_short_len) << SHORT_SH;
    long_len  = LEN_W'(cfg_long_len) << LONG_SH;
    sel_len   = (kind == ZQ_LONG) ? long_len : short_len;
    win_len   = (sel_len == '0) ? LEN_W'(1) : sel_len;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    zq_rank_timer #(.LEN_W(LEN_W)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .load (load[r]),
      .len  (win_len),
      .busy (busy[r])
    );
  end
endmodule

// File: rtl/zq_cal_sched_chk.sv
module zq_cal_sched_chk #(
  parameter int NUM_RANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_RANKS-1:0] gnt,
  input logic [NUM_RANKS-1:0] zqcs_req,
  input logic [NUM_RANKS-1:0] zqcl_req,
  input logic [NUM_RANKS-1:0] busy
);
  logic [NUM_RANKS-1:0] req;
  assign req = zqcs_req | zqcl_req;

  assert_req_busy_excl_R10: assert property (@(posedge clk) disable iff (rst)
    (req & busy) == '0);

  assert_one_kind_R10: assert property (@(posedge clk) disable iff (rst)
    !((|zqcs_req) && (|zqcl_req)));

  assert_hold_until_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (req & ~gnt) != '0 |=> ((($past(req) & ~$past(gnt)) & ~req) == '0));

  assert_grant_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (req & gnt) != '0 |=> (($past(req & gnt) & req) == '0));

  assert_grant_starts_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (req & gnt) != '0 |=> (($past(req & gnt) & ~busy) == '0));

  assert_busy_needs_grant_R7: assert property (@(posedge clk) disable iff (rst)
    ((busy & ~$past(busy)) & ~$past(req & gnt)) == '0);

  assert_req_after_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (req & ~$past(req)) != '0 |-> ($past(busy) == '0));
endmodule

bind zq_cal_sched zq_cal_sched_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gnt      (gnt),
  .zqcs_req (zqcs_req),
  .zqcl_req (zqcl_req),
  .busy     (busy)
);

// File: tb/sim_zq_cal_sched.sv
module sim_zq_cal_sched;
  localparam int NR = 3;
  localparam int IW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          refi_tick = 1'b0, init_cal = 1'b0, en = 1'b1, par = 1'b1;
  logic [IW-1:0] interval = 8'd3;
  logic [2:0]    slen = 3'd1;
  logic [4:0]    llen = 5'd1;
  logic [NR-1:0] gnt = '0, agnt = '0, stray = '0;
  logic [NR-1:0] cs, cl, bsy;

  zq_cal_sched #(.NUM_RANKS(NR), .INTV_W(IW)) u0 (
    .clk(clk), .rst(rst), .refi_tick(refi_tick), .init_cal(init_cal),
    .cfg_periodic_en(en), .cfg_interval(interval), .cfg_short_len(slen),
    .cfg_long_len(llen), .cfg_parallel(par), .gnt(gnt),
    .zqcs_req(cs), .zqcl_req(cl), .busy(bsy)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R1";
  int tick_period = 0, gdelay = 2, wcnt[NR];
  bit stray_en = 0;
  int run_len = 0, last_len = 0, req_cycles = 0, cs_rises = 0;
  logic [NR-1:0] prev_cs = '0;

  // behavioural reference
  int m_cnt = 0, m_idx = 0, m_left[NR], win;
  bit m_pcs = 0, m_pcl = 0, m_act = 0, m_par = 0, m_long = 0, m_exp, m_st, m_sp;
  bit [NR-1:0] m_req = '0, m_busy = '0, m_ld;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_idx = 0; m_pcs = 0; m_pcl = 0; m_act = 0; m_par = 0;
      m_long = 0; m_req = '0; m_busy = '0;
      for (int r = 0; r < NR; r++) m_left[r] = 0;
    end else begin
      m_exp = 0;
      if (init_cal || !en) m_cnt = 0;
      else if (refi_tick) begin
        if (m_cnt + 1 >= int'(interval)) begin m_exp = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_st = !m_act && (m_pcs || m_pcl);
      m_sp = m_act && m_req == '0 && m_busy == '0;
      m_ld = m_req & gnt;
      win = m_long ? int'(llen) * 32 : int'(slen) * 16;
      if (win == 0) win = 1;
      for (int r = 0; r < NR; r++) begin
        if (m_ld[r]) begin m_busy[r] = 1; m_left[r] = win; end
        else if (m_busy[r]) begin
          if (m_left[r] == 1) m_busy[r] = 0;
          else m_left[r] = m_left[r] - 1;
        end
      end
      m_req = m_req & ~gnt;
      if (m_st) begin
        m_long = m_pcl;
        if (m_pcl) m_pcl = 0; else m_pcs = 0;
        m_par = par; m_idx = 0; m_act = 1;
        m_req = par ? '1 : NR'(1);
      end else if (m_sp) begin
        if (m_par || m_idx == NR - 1) m_act = 0;
        else begin m_idx = m_idx + 1; m_req = NR'(1) << m_idx; end
      end
      if (init_cal) m_pcl = 1;
      if (m_exp) m_pcs = 1;
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d, expected <= 150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // compare, measure and drive at the falling edge
  always @(negedge clk) begin
    logic [NR-1:0] ecs, ecl;
    ecs = m_long ? '0 : m_req;
    ecl = m_long ? m_req : '0;
    if (!rst) begin
      compared++;
      if (cs !== ecs || cl !== ecl || bsy !== m_busy) begin
        mismatched++;
        $display("FAIL %s cyc=%0d cs=%b cl=%b busy=%b expected cs=%b cl=%b busy=%b",
                 tag, cyc, cs, cl, bsy, ecs, ecl, m_busy);
      end
      compared++;
      if ((cs & cl) != '0 || ((cs | cl) & bsy) != '0) begin
        mismatched++;
        $display("FAIL R10 cyc=%0d cs=%b cl=%b busy=%b expected disjoint", cyc, cs, cl, bsy);
      end
    end
    if (bsy[0]) run_len++;
    else if (run_len > 0) begin last_len = run_len; run_len = 0; end
    if ((cs | cl) != '0) req_cycles++;
    if ((cs & ~prev_cs) != '0) cs_rises++;
    prev_cs = cs;
    for (int r = 0; r < NR; r++) begin
      if (!rst && (cs[r] || cl[r])) begin
        if (wcnt[r] >= gdelay) begin agnt[r] = 1'b1; wcnt[r] = 0; end
        else begin agnt[r] = 1'b0; wcnt[r]++; end
      end else begin
        agnt[r] = 1'b0; wcnt[r] = 0;
      end
    end
    stray = stray_en ? NR'(cyc % 7) : '0;
    gnt = agnt | stray;
    refi_tick = (tick_period > 0) && (cyc % tick_period == 0);
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string rq, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic pulse_init();
    @(negedge clk); init_cal = 1'b1;
    @(negedge clk); init_cal = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) wcnt[r] = 0;
    wait_cycles(5);
    rst = 1'b0;
    wait_cycles(1);
    // R1: idle after reset
    check("R1 outputs after reset", int'({cs, cl, bsy}), 0);

    tag = "R2"; cs_rises = 0; tick_period = 7;
    wait_cycles(200);
    check("R2 periodic short round seen", int'(cs_rises > 0), 1);

    tag = "R8"; last_len = 0;
    wait_cycles(150);
    check("R7 short window with field 1", last_len, 16);

    tag = "R9"; par = 1'b0;
    wait_cycles(400);

    tag = "R4"; tick_period = 5;
    pulse_init();
    wait_cycles(300);

    tag = "R5"; par = 1'b1; interval = 8'd1; tick_period = 1; gdelay = 10;
    wait_cycles(300);

    tag = "R7"; gdelay = 1; tick_period = 9; interval = 8'd2; slen = 3'd0; llen = 5'd2;
    wait_cycles(100);
    check("R7 short window with field 0", last_len, 1);
    pulse_init();
    wait_cycles(300);
    par = 1'b0;
    pulse_init();
    wait_cycles(300);
    slen = 3'd1;

    tag = "R6"; stray_en = 1; par = 1'b1;
    wait_cycles(300);
    stray_en = 0;

    tag = "R3"; tick_period = 0;
    wait_cycles(400);
    en = 1'b0; tick_period = 1; req_cycles = 0;
    wait_cycles(200);
    check("R3 no requests while disabled", req_cycles, 0);
    en = 1'b1; tick_period = 4; interval = 8'd3;
    wait_cycles(150);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule